// File: doc/BRIEF.md
# Feed-Sequence Watchdog Timer

This block is a watchdog that supervises software by expecting a periodic two-write "feed" ritual. It counts down a 24-bit value, one step for every four clocks, from a software-chosen timeout constant. If the count runs out, or if software fumbles the feed ritual, the block either raises a reset request for the system reset controller or raises an interrupt, depending on the selected mode.

Software writes an arm bit and an optional reset-mode bit, and then performs one valid feed, which starts the countdown. From then on the watchdog cannot be switched off by software. Only a system reset clears it, or the expiry of an interrupt-mode timeout, which disarms it. A sticky cause flag records a watchdog-initiated reset. The flag survives the system reset and is cleared by power-on reset or by software. A debug input freezes the countdown while a debugger halts the processor.

Top module: `fsw_watchdog`

## Requirements
- R1: After reset, both outputs are low, the control register (address 0) reads zero, and the reload register (address 1) and the count (address 3) both read 0x0000FF.
- R2: Setting the arm bit (control bit 0) alone does not start counting. Without a valid feed, the count stays at its reset value and no malformed feed sequence causes any action.
- R3: A valid feed writes exactly 0x000000AA to the feed register (address 2) and then exactly 0x00000055 as the very next register access. It loads the count from the reload register. When armed, a timeout occurs exactly 4*(R+1) clocks after the clock edge that accepts the 0x55 write, where R is the reload value.
- R4: While running, the count read at address 3 falls by one every four clocks, starting at the reload value.
- R5: Once set, the arm bit and the reset-mode bit (control bit 1) ignore writes of zero. The running indication (control bit 4, read-only) stays high.
- R6: While running, any register access between a 0xAA write and the 0x55 write causes the timeout action at the edge that accepts that access. This covers a read, a write to another register, and a repeated 0xAA. A feed-register write of any value other than 0xAA outside the sequence has the same effect.
- R7: A timeout in interrupt mode (control bit 1 zero at the last valid feed) drives the interrupt output high and keeps the reset request low. It clears the running and arm bits and freezes the count. Writing 1 to control bit 3 clears the interrupt.
- R8: A timeout in reset mode drives the reset request high and keeps it high until a system reset. It also sets the cause flag (control bit 2).
- R9: The cause flag survives the system reset. It is cleared by the power-on reset input or by a control write with bit 2 at zero. A control write with bit 2 at one leaves the flag set.
- R10: While the debug hold input is high, the count and the prescaler do not advance, so the timeout is delayed by exactly the number of held clocks.
- R11: A reset-mode bit set after the watchdog starts running has no effect until the next valid feed. A timeout before that feed is still handled in interrupt mode.
- R12: A new reload value written while running has no effect on the current countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset; leaves the cause flag intact |
| por | input | 1 | Synchronous active-high power-on reset; clears everything including the cause flag |
| acc_en | input | 1 | Register access strobe, one access per cycle it is high |
| acc_we | input | 1 | High for a write access, low for a read |
| acc_addr | input | 2 | Register select: 0 control, 1 reload, 2 feed, 3 count |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the selected register, valid in the same cycle |
| dbg_hold | input | 1 | Freezes the countdown while high |
| wdt_reset_req | output | 1 | Reset request, held until a system reset |
| wdt_irq | output | 1 | Watchdog interrupt, held until cleared by software |

## Verification
A corrupted feed state shows up on the outputs at the very next register access. A missed valid feed surfaces as a premature timeout. A false validation makes a deliberate fumble fail to raise the request at the expected edge. A wrong prescaler phase or a wrong count load shifts the timeout edge by at least one clock, so the bench measures that edge exactly across a sweep of reload values in both modes. It also reads the count on every cycle of one full countdown. Errors in the lock, flag and mode-latching state appear only at readback or at the next timeout, so each of these is probed directly after the stimulus that could disturb it.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL   = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_FEED   = 2'd2,
        SEL_COUNT  = 2'd3
    } reg_sel_e;

    // control register bit positions
    localparam int B_ARM  = 0;
    localparam int B_MODE = 1;
    localparam int B_FLAG = 2;
    localparam int B_IRQ  = 3;
    localparam int B_LIVE = 4;

    localparam logic [7:0] KEY_OPEN  = 8'hAA;
    localparam logic [7:0] KEY_CLOSE = 8'h55;

    typedef enum logic {
        FS_IDLE,
        FS_OPEN
    } feed_state_e;

    typedef struct packed {
        logic              en;
        logic              we;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic good;
        logic fumble;
    } feed_res_t;

    function automatic logic is_write_to(bus_req_t r, reg_sel_e s);
        return r.en && r.we && (r.sel == s);
    endfunction

    function automatic logic key_match(bus_req_t r, logic [7:0] key);
        return r.wdata == DATA_W'(key);
    endfunction

endpackage

// File: rtl/fsw_feed_seq.sv
module fsw_feed_seq
    import fsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_req_t  req,
    output feed_res_t res
);

    feed_state_e st_q, st_d;

    always_comb begin
        st_d       = st_q;
        res.good   = 1'b0;
        res.fumble = 1'b0;
        if (req.en) begin
            unique case (st_q)
                FS_IDLE: begin
                    if (is_write_to(req, SEL_FEED)) begin
                        if (key_match(req, KEY_OPEN)) st_d = FS_OPEN;
                        else                          res.fumble = 1'b1;
                    end
                end
                FS_OPEN: begin
                    st_d = FS_IDLE;
                    if (is_write_to(req, SEL_FEED) && key_match(req, KEY_CLOSE))
                        res.good = 1'b1;
                    else
                        res.fumble = 1'b1;
                end
                default: st_d = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= FS_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/fsw_tick_gen.sv
module fsw_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;

    assign tick = run && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) phase_q <= '0;
        else if (run)       phase_q <= tick ? '0 : phase_q + 1'b1;
    end

endmodule

// File: rtl/fsw_downcount.sv
module fsw_downcount #(
    parameter int          W    = 24,
    parameter int unsigned INIT = 255
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic [W-1:0] value,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    assign value  = cnt_q;
    assign expire = tick && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst)                       cnt_q <= W'(INIT);
        else if (load)                 cnt_q <= load_val;
        else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

endmodule

// File: rtl/fsw_watchdog.sv
module fsw_watchdog
    import fsw_pkg::*;
#(
    parameter int          CNT_W       = 24,
    parameter int          PRE_DIV     = 4,
    parameter int unsigned RELOAD_INIT = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    input  logic              dbg_hold,
    output logic              wdt_reset_req,
    output logic              wdt_irq
);

    logic sys_rst;
    assign sys_rst = rst || por;

    bus_req_t  req;
    feed_res_t fres;

    assign req.en    = acc_en;
    assign req.we    = acc_we;
    assign req.sel   = reg_sel_e'(acc_addr);
    assign req.wdata = acc_wdata;

    logic             arm_q, mode_q, live_q, live_mode_q;
    logic             irq_q, rreq_q, flag_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic             tick, expire, run;
    logic             timeout, to_reset, to_irq, ctrl_wr;

    fsw_feed_seq u_feed (
        .clk (clk),
        .rst (sys_rst),
        .req (req),
        .res (fres)
    );

    assign run = live_q && !rreq_q && !dbg_hold;

    fsw_tick_gen #(.DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst     (sys_rst),
        .run     (run),
        .restart (fres.good),
        .tick    (tick)
    );

    fsw_downcount #(.W(CNT_W), .INIT(RELOAD_INIT)) u_cnt (
        .clk      (clk),
        .rst      (sys_rst),
        .load     (fres.good),
        .load_val (reload_q),
        .tick     (tick),
        .value    (cnt),
        .expire   (expire)
    );

    assign ctrl_wr  = is_write_to(req, SEL_CTRL);
    assign timeout  = !sys_rst && live_q && !rreq_q && (expire || fres.fumble);
    assign to_reset = timeout && live_mode_q;
    assign to_irq   = timeout && !live_mode_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            arm_q       <= 1'b0;
            mode_q      <= 1'b0;
            live_q      <= 1'b0;
            live_mode_q <= 1'b0;
            irq_q       <= 1'b0;
            rreq_q      <= 1'b0;
            reload_q    <= CNT_W'(RELOAD_INIT);
        end else begin
            if (to_irq)                             arm_q <= 1'b0;
            else if (ctrl_wr && acc_wdata[B_ARM])   arm_q <= 1'b1;

            if (ctrl_wr && acc_wdata[B_MODE])       mode_q <= 1'b1;

            if (to_irq) begin
                live_q <= 1'b0;
            end else if (fres.good && arm_q) begin
                live_q      <= 1'b1;
                live_mode_q <= mode_q;
            end

            if (to_irq)                             irq_q <= 1'b1;
            else if (ctrl_wr && acc_wdata[B_IRQ])   irq_q <= 1'b0;

            if (to_reset)                           rreq_q <= 1'b1;

            if (is_write_to(req, SEL_RELOAD))       reload_q <= acc_wdata[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (por)                                 flag_q <= 1'b0;
        else if (to_reset)                       flag_q <= 1'b1;
        else if (ctrl_wr && !acc_wdata[B_FLAG])  flag_q <= 1'b0;
    end

    always_comb begin
        acc_rdata = '0;
        unique case (reg_sel_e'(acc_addr))
            SEL_CTRL: begin
                acc_rdata[B_ARM]  = arm_q;
                acc_rdata[B_MODE] = mode_q;
                acc_rdata[B_FLAG] = flag_q;
                acc_rdata[B_IRQ]  = irq_q;
                acc_rdata[B_LIVE] = live_q;
            end
            SEL_RELOAD: acc_rdata = DATA_W'(reload_q);
            SEL_COUNT:  acc_rdata = DATA_W'(cnt);
            default:    acc_rdata = '0;
        endcase
    end

    assign wdt_reset_req = rreq_q;
    assign wdt_irq       = irq_q;

endmodule

// File: rtl/fsw_watchdog_chk.sv
module fsw_watchdog_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             por,
    input logic             acc_en,
    input logic             acc_we,
    input logic [1:0]       acc_addr,
    input logic             dbg_hold,
    input logic             wdt_reset_req,
    input logic             wdt_irq,
    input logic             live,
    input logic             arm,
    input logic             flag,
    input logic [CNT_W-1:0] count
);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (rst || por)
        wdt_reset_req |=> wdt_reset_req);

    assert_flag_with_req_R8: assert property (@(posedge clk) disable iff (rst || por)
        $rose(flag) |-> wdt_reset_req);

    assert_dbg_freeze_R10: assert property (@(posedge clk) disable iff (rst || por)
        (dbg_hold && !acc_en) |=> $stable(count));

    assert_single_step_R4: assert property (@(posedge clk) disable iff (rst || por)
        (live && !dbg_hold && !acc_en && !wdt_reset_req) |=>
            (count == $past(count) || count == $past(count) - CNT_W'(1)));

    assert_arm_oneway_R5: assert property (@(posedge clk) disable iff (rst || por)
        $fell(arm) |-> $rose(wdt_irq));

    assert_irq_disarms_R7: assert property (@(posedge clk) disable iff (rst || por)
        $rose(wdt_irq) |-> (!live && !wdt_reset_req));

    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (por)
        $fell(flag) |-> $past(acc_en && acc_we && acc_addr == 2'd0));

endmodule

bind fsw_watchdog fsw_watchdog_chk #(.CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .por           (por),
    .acc_en        (acc_en),
    .acc_we        (acc_we),
    .acc_addr      (acc_addr),
    .dbg_hold      (dbg_hold),
    .wdt_reset_req (wdt_reset_req),
    .wdt_irq       (wdt_irq),
    .live          (live_q),
    .arm           (arm_q),
    .flag          (flag_q),
    .count         (cnt)
);

// File: tb/fsw_watchdog_tb_top.sv
module fsw_watchdog_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_addr = 2'd0;
    logic [31:0] acc_wdata = 32'd0;
    logic [31:0] acc_rdata;
    logic        dbg_hold = 1'b0;
    logic        wdt_reset_req;
    logic        wdt_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fsw_watchdog dut_i (
        .clk           (clk),
        .rst           (rst),
        .por           (por),
        .acc_en        (acc_en),
        .acc_we        (acc_we),
        .acc_addr      (acc_addr),
        .acc_wdata     (acc_wdata),
        .acc_rdata     (acc_rdata),
        .dbg_hold      (dbg_hold),
        .wdt_reset_req (wdt_reset_req),
        .wdt_irq       (wdt_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic feed();
        wr(2'd2, 32'h0000_00AA);
        wr(2'd2, 32'h0000_0055);
    endtask

    task automatic sys_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pwr_reset();
        por = 1'b1; rst = 1'b1;
        repeat (2) @(negedge clk);
        por = 1'b0; rst = 1'b0;
    endtask

    // counts edges until the chosen output is high
    task automatic wait_out(input bit want_irq, input int start, input int limit, output int n);
        n = start;
        while (!(want_irq ? wdt_irq : wdt_reset_req) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int n;
        int rl [8] = '{0, 1, 2, 3, 4, 7, 10, 15};

        repeat (3) @(negedge clk);
        por = 1'b0; rst = 1'b0;

        // R1 reset state
        chk("R1 reset_req", {31'd0, wdt_reset_req}, 32'd0);
        chk("R1 irq", {31'd0, wdt_irq}, 32'd0);
        rd(2'd0, d); chk("R1 ctrl", d, 32'd0);
        rd(2'd1, d); chk("R1 reload", d, 32'hFF);
        rd(2'd3, d); chk("R1 count", d, 32'hFF);

        // R2 armed but never fed; a broken sequence does nothing
        wr(2'd0, 32'h3);
        wr(2'd2, 32'hAA);
        rd(2'd0, d);
        wr(2'd2, 32'h12);
        repeat (60) @(negedge clk);
        chk("R2 no reset", {31'd0, wdt_reset_req}, 32'd0);
        chk("R2 no irq", {31'd0, wdt_irq}, 32'd0);
        rd(2'd3, d); chk("R2 count idle", d, 32'hFF);

        // R3 sweep over reload values and both modes
        foreach (rl[i]) begin
            for (int m = 0; m < 2; m++) begin
                sys_reset();
                wr(2'd1, rl[i]);
                wr(2'd0, (m == 1) ? 32'h3 : 32'h1);
                feed();
                wait_out(m == 0, 0, 4 * rl[i] + 40, n);
                chk("R3 timeout edge", n, 4 * (rl[i] + 1));
                if (m == 0) chk("R7 no reset in irq mode", {31'd0, wdt_reset_req}, 32'd0);
                else        chk("R8 no irq in reset mode", {31'd0, wdt_irq}, 32'd0);
            end
        end

        // R4 count readback every cycle, irq mode, then R7
        sys_reset();
        wr(2'd1, 32'd5);
        wr(2'd0, 32'h1);
        feed();
        for (int k = 0; k < 24; k++) begin
            rd(2'd3, d);
            chk("R4 count", d, 32'(5 - k / 4));
        end
        chk("R7 irq high", {31'd0, wdt_irq}, 32'd1);
        chk("R7 reset low", {31'd0, wdt_reset_req}, 32'd0);
        rd(2'd0, d);
        chk("R7 disarmed", {30'd0, d[4], d[0]}, 32'd0);
        repeat (10) @(negedge clk);
        rd(2'd3, d); chk("R7 count frozen", d, 32'd0);
        wr(2'd0, 32'h8);
        chk("R7 irq cleared", {31'd0, wdt_irq}, 32'd0);

        // R5 lock of arm and mode
        sys_reset();
        wr(2'd0, 32'h3);
        feed();
        wr(2'd0, 32'h0);
        rd(2'd0, d);
        chk("R5 locked bits", {27'd0, d[4], 2'd0, d[1:0]}, 32'h13);

        // R6 fumbled sequences while running
        for (int v = 0; v < 4; v++) begin
            sys_reset();
            wr(2'd1, 32'd100);
            wr(2'd0, 32'h3);
            feed();
            if (v < 3) begin
                wr(2'd2, 32'hAA);
                chk("R6 not early", {31'd0, wdt_reset_req}, 32'd0);
            end
            case (v)
                0: rd(2'd0, d);
                1: wr(2'd1, 32'd7);
                2: wr(2'd2, 32'hAA);
                default: wr(2'd2, 32'h12);
            endcase
            chk("R6 fumble trips", {31'd0, wdt_reset_req}, 32'd1);
        end
        repeat (10) @(negedge clk);
        chk("R8 request held", {31'd0, wdt_reset_req}, 32'd1);
        rd(2'd0, d); chk("R8 flag set", {31'd0, d[2]}, 32'd1);

        // R9 flag life cycle
        sys_reset();
        chk("R9 request cleared by reset", {31'd0, wdt_reset_req}, 32'd0);
        rd(2'd0, d); chk("R9 flag survives reset", {31'd0, d[2]}, 32'd1);
        wr(2'd0, 32'h4);
        rd(2'd0, d); chk("R9 write one keeps", {31'd0, d[2]}, 32'd1);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R9 write zero clears", {31'd0, d[2]}, 32'd0);
        sys_reset();
        wr(2'd1, 32'd0);
        wr(2'd0, 32'h3);
        feed();
        wait_out(1'b0, 0, 20, n);
        pwr_reset();
        rd(2'd0, d); chk("R9 por clears", {31'd0, d[2]}, 32'd0);

        // R10 debug hold delays timeout
        sys_reset();
        wr(2'd1, 32'd3);
        wr(2'd0, 32'h3);
        feed();
        dbg_hold = 1'b1;
        repeat (9) @(negedge clk);
        rd(2'd3, d); chk("R10 count held", d, 32'd3);
        dbg_hold = 1'b0;
        wait_out(1'b0, 10, 80, n);
        chk("R10 delayed timeout", n, 32'd26);

        // R11 mode set after start waits for next feed
        sys_reset();
        wr(2'd1, 32'd2);
        wr(2'd0, 32'h1);
        feed();
        wr(2'd0, 32'h2);
        n = 0;
        while (!wdt_irq && !wdt_reset_req && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk("R11 irq taken", {31'd0, wdt_irq}, 32'd1);
        chk("R11 no reset", {31'd0, wdt_reset_req}, 32'd0);

        // R12 reload change during countdown
        sys_reset();
        wr(2'd1, 32'd4);
        wr(2'd0, 32'h3);
        feed();
        wr(2'd1, 32'd40);
        wait_out(1'b0, 1, 200, n);
        chk("R12 old reload used", n, 32'd20);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule